// File: doc/BRIEF.md
# Receive Byte Queue with Programmable Threshold

This block is the receive half of a serial port controller. Bytes that have already been deserialised arrive on a byte-wide input with a one-cycle valid strobe. The block stores them in a 16-entry circular queue. When the fill level reaches a threshold chosen by software, it raises a "queue at threshold" status flag. If the interrupt is enabled, it also raises a level interrupt. Software drains the queue by reading the data register. It controls acceptance, the interrupt, the threshold and flushing through a small register bus with four registers.

The register bus uses a 2-bit address: 0 is control, 1 is queue control, 2 is status and 3 is receive data. A write takes effect at the clock edge where `bus_wr` is high. A read returns its value on `bus_rdata` in the cycle after the edge that sampled `bus_rd`. A separate strobe reports a line break, and the block latches it as a sticky status bit.

Top module: `rx_trigger_fifo`

## Requirements
- R1: The queue holds up to 16 bytes and returns them in arrival order. This holds across any number of wraps of its internal ring positions.
- R2: Bits [7:6] of the queue-control register (address 1) select the threshold: 00 is 1, 01 is 4, 10 is 8 and 11 is 14. After reset the field is 00, so the threshold is 1. Bits [7:6] read back as written, and all other bits read as 0.
- R3: A write to address 1 with bit 1 set empties the queue and clears the threshold flag (status bit 1). A later data read then returns 0x00.
- R4: The queue accepts a byte only while control bit 4 (address 0) is 1. A byte that arrives while 16 bytes are already held is dropped.
- R5: When a stored byte brings the level to at least the threshold, status bit 1 is set. If control bit 6 is 1, `rx_irq` is also asserted.
- R6: A read of address 3 on a non-empty queue returns the oldest byte and removes it. If the remaining level is below the threshold, status bit 1 clears. A read on an empty queue returns 0x00 and changes nothing.
- R7: A write to address 0 with bit 6 equal to 0 deasserts `rx_irq`.
- R8: A write to address 2 with bit 1 or bit 0 equal to 0 deasserts `rx_irq`. Writing 0 to bit 1 also clears the threshold flag.
- R9: A pulse on `rx_break` sets status bit 4. A write to address 2 with bit 4 equal to 0 clears it.
- R10: A byte arrival and a data read in the same cycle both take effect and leave the level unchanged. The flag and interrupt are then evaluated against that level.
- R11: After reset, `rx_irq` is 0, the queue is empty and the control and status registers read 0x00. `rx_irq` and `bus_rdata` are registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | One-cycle strobe qualifying rx_data |
| rx_break | input | 1 | One-cycle strobe reporting a line break |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Registered read data |
| rx_irq | output | 1 | Level receive interrupt |

## Verification
The bench builds the block with its default parameters: a 16-entry queue of 8-bit bytes. Because the queue is that small, the bench can fill it past full and drain it past empty under every one of the four threshold settings. It checks the flag and the interrupt after every single arrival and every single read. Repeated partial fill and drain rounds move the ring positions through several wraps. Further directed steps cover each interrupt-clearing write, a flush, a break and an arrival that coincides with a read.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_QCTL = 2'd1,
    RA_STAT = 2'd2,
    RA_DATA = 2'd3
  } reg_addr_e;

  localparam int CTRL_RXEN  = 4;
  localparam int CTRL_RXIE  = 6;
  localparam int QCTL_FLUSH = 1;
  localparam int STAT_ACK   = 0;
  localparam int STAT_THR   = 1;
  localparam int STAT_BRK   = 4;

  // Threshold for a 2-bit selector, scaled from the queue depth.
  function automatic int thr_level(input logic [1:0] sel, input int depth);
    case (sel)
      2'd0:    return 1;
      2'd1:    return depth / 4;
      2'd2:    return depth / 2;
      default: return depth - 2;
    endcase
  endfunction

endpackage

// File: rtl/rxq_ring.sv
module rxq_ring #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic          flush,
  input  logic [DW-1:0] wr_data,
  output logic [CW-1:0] level,
  output logic [DW-1:0] head_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  // Storage has no reset so it maps onto distributed or block RAM.
  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign head_data = mem[rd_ptr];

  AST_RING_BOUND: assert property (@(posedge clk) disable iff (rst)
    level <= CW'(DEPTH)); // R1

endmodule

// File: rtl/rxq_threshold.sv
module rxq_threshold #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [1:0]    sel_in,
  output logic [1:0]    sel,
  output logic [CW-1:0] thr
);
  always_ff @(posedge clk) begin
    if (rst)       sel <= 2'd0;
    else if (load) sel <= sel_in;
  end

  assign thr = CW'(rxq_pkg::thr_level(sel, DEPTH));

endmodule

// File: rtl/rx_trigger_fifo.sv
module rx_trigger_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_valid,
  input  logic          rx_break,
  input  logic [1:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic          rx_irq
);
  import rxq_pkg::*;

  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [7:0]    ctrl_q, ctrl_nx;
  logic          thr_flag, brk_flag;
  logic [CW-1:0] level, level_nx, thr;
  logic [1:0]    thr_sel;
  logic [DW-1:0] head_data;
  logic          wr_ctrl, wr_qctl, wr_stat, rd_data;
  logic          push, pop, flush, irq_clr;

  assign wr_ctrl = bus_wr && (bus_addr == RA_CTRL);
  assign wr_qctl = bus_wr && (bus_addr == RA_QCTL);
  assign wr_stat = bus_wr && (bus_addr == RA_STAT);
  assign rd_data = bus_rd && (bus_addr == RA_DATA);

  assign ctrl_nx = wr_ctrl ? bus_wdata : ctrl_q;
  assign flush   = wr_qctl && bus_wdata[QCTL_FLUSH];
  assign pop     = rd_data && (level != '0) && !flush;
  assign push    = rx_valid && ctrl_q[CTRL_RXEN] && (level < FULL) && !flush;

  assign level_nx = level + {{(CW-1){1'b0}}, push} - {{(CW-1){1'b0}}, pop};
  assign irq_clr  = (wr_ctrl && !bus_wdata[CTRL_RXIE]) ||
                    (wr_stat && (!bus_wdata[STAT_THR] || !bus_wdata[STAT_ACK]));

  rxq_ring #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) i_ring (
    .clk(clk), .rst(rst), .push(push), .pop(pop), .flush(flush),
    .wr_data(rx_data), .level(level), .head_data(head_data)
  );

  rxq_threshold #(.DEPTH(DEPTH), .CW(CW)) i_thr (
    .clk(clk), .rst(rst), .load(wr_qctl), .sel_in(bus_wdata[7:6]),
    .sel(thr_sel), .thr(thr)
  );

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else     ctrl_q <= ctrl_nx;
  end

  // Threshold flag: arrival sets, drain below threshold or explicit write clears.
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      thr_flag <= 1'b0;
    end else if (push && level_nx >= thr) begin
      thr_flag <= 1'b1;
    end else if ((pop && level_nx < thr) || (wr_stat && !bus_wdata[STAT_THR])) begin
      thr_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                   brk_flag <= 1'b0;
    else if (rx_break)                         brk_flag <= 1'b1;
    else if (wr_stat && !bus_wdata[STAT_BRK])  brk_flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rx_irq <= 1'b0;
    else if (push && level_nx >= thr && ctrl_nx[CTRL_RXIE])
      rx_irq <= 1'b1;
    else if (irq_clr)
      rx_irq <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        RA_CTRL: bus_rdata <= ctrl_q;
        RA_QCTL: bus_rdata <= {thr_sel, 6'b0};
        RA_STAT: bus_rdata <= {3'b0, brk_flag, 2'b0, thr_flag, 1'b0};
        default: bus_rdata <= (level != '0) ? 8'(head_data) : 8'h00;
      endcase
    end
  end

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    flush |=> (level == '0 && !thr_flag)); // R3
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (level == FULL && !rd_data && !flush) |=> level == FULL); // R4
  AST_GATED_OFF: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[CTRL_RXEN] && !rd_data && !flush) |=> level == $past(level)); // R4
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_data && level == '0 && !push && !flush) |=> (level == '0 && bus_rdata == 8'h00)); // R6
  AST_CTRL_CLR: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && !bus_wdata[CTRL_RXIE] && !push) |=> !rx_irq); // R7
  AST_STAT_CLR: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && !bus_wdata[STAT_THR] && !push) |=> (!rx_irq && !thr_flag)); // R8
  AST_BREAK_SET: assert property (@(posedge clk) disable iff (rst)
    rx_break |=> brk_flag); // R9
  AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (push && pop) |=> level == $past(level)); // R10

endmodule

// File: tb/test_rx_trigger_fifo.sv
`timescale 1ns/1ps
module test_rx_trigger_fifo;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] rx_data = '0;
  logic       rx_valid = 1'b0, rx_break = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       rx_irq;

  int checks = 0, fails = 0;
  logic [7:0] mq[$];
  logic [7:0] d;
  bit done = 0;

  always #4 clk = ~clk;

  rx_trigger_fifo i_rx_trigger_fifo (
    .clk(clk), .rst(rst), .rx_data(rx_data), .rx_valid(rx_valid), .rx_break(rx_break),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rx_irq(rx_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] v);
    @(negedge clk); bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; v = bus_rdata;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); rx_data = b; rx_valid = 1'b1;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  function automatic int thr_of(input int sel);
    return (sel == 0) ? 1 : (sel == 1) ? 4 : (sel == 2) ? 8 : 14;
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      finish_run();
    end
  end

  initial begin
    int rdf_m, irq_m, t;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R11 reset state, R2 default selector
    chk("R11 irq", rx_irq, 0);
    rd(2'd2, d); chk("R11 status", d, 0);
    rd(2'd0, d); chk("R11 ctrl", d, 0);
    rd(2'd1, d); chk("R2 default sel", d, 0);
    rd(2'd3, d); chk("R6 empty read", d, 0);

    // R4 receiver disabled: byte ignored
    push(8'h77);
    rd(2'd3, d); chk("R4 disabled drop", d, 0);

    // R2/R5/R6/R4/R7 sweep over every threshold
    for (int sel = 0; sel < 4; sel++) begin
      t = thr_of(sel);
      wr(2'd0, 8'h50);
      wr(2'd1, 8'((sel << 6) | 2));
      rd(2'd1, d); chk("R2 sel readback", d, sel << 6);
      mq.delete(); rdf_m = 0; irq_m = 0;
      for (int i = 0; i < 17; i++) begin
        logic [7:0] b;
        b = 8'(sel * 32 + i);
        push(b);
        if (mq.size() < 16) begin
          mq.push_back(b);
          if (mq.size() >= t) begin rdf_m = 1; irq_m = 1; end
        end
        chk("R5 irq on fill", rx_irq, irq_m);
        rd(2'd2, d); chk("R5 flag on fill", d[1], rdf_m);
      end
      wr(2'd0, 8'h10);
      chk("R7 ctrl clears irq", rx_irq, 0);
      for (int i = 0; i < 17; i++) begin
        int e;
        rd(2'd3, d);
        e = 0;
        if (mq.size() > 0) begin
          e = mq.pop_front();
          if (mq.size() < t) rdf_m = 0;
        end
        chk("R1 R4 R6 data order", d, e);
        rd(2'd2, d); chk("R6 flag on drain", d[1], rdf_m);
      end
    end

    // R1 wrap of ring positions
    wr(2'd1, 8'h02);
    wr(2'd0, 8'h10);
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < 11; i++) push(8'(8'hA0 + r * 11 + i));
      for (int i = 0; i < 11; i++) begin
        rd(2'd3, d); chk("R1 wrap order", d, (8'hA0 + r * 11 + i) & 8'hFF);
      end
    end

    // R8 status-write clears
    wr(2'd1, 8'h42);
    wr(2'd0, 8'h50);
    for (int i = 0; i < 4; i++) push(8'(8'h10 + i));
    chk("R5 irq at 4", rx_irq, 1);
    wr(2'd2, 8'hFF); chk("R8 all-ones keeps irq", rx_irq, 1);
    wr(2'd2, 8'hFE); chk("R8 bit0 clears irq", rx_irq, 0);
    rd(2'd2, d); chk("R8 bit0 keeps flag", d[1], 1);
    push(8'h14); chk("R5 irq re-raised", rx_irq, 1);
    wr(2'd2, 8'hFD); chk("R8 bit1 clears irq", rx_irq, 0);
    rd(2'd2, d); chk("R8 bit1 clears flag", d[1], 0);

    // R10 simultaneous arrival and read (level 5, threshold 4)
    @(negedge clk);
    rx_data = 8'hA5; rx_valid = 1'b1; bus_addr = 2'd3; bus_rd = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; bus_rd = 1'b0; d = bus_rdata;
    chk("R10 popped oldest", d, 8'h10);
    chk("R10 irq re-evaluated", rx_irq, 1);
    rd(2'd2, d); chk("R10 flag", d[1], 1);
    begin
      logic [7:0] exp5[5] = '{8'h11, 8'h12, 8'h13, 8'h14, 8'hA5};
      for (int i = 0; i < 5; i++) begin
        rd(2'd3, d); chk("R10 level kept", d, exp5[i]);
      end
    end
    rd(2'd3, d); chk("R10 empty after", d, 0);

    // R3 flush
    wr(2'd1, 8'h02);
    for (int i = 0; i < 3; i++) push(8'(8'h30 + i));
    rd(2'd2, d); chk("R3 flag before flush", d[1], 1);
    wr(2'd1, 8'h02);
    rd(2'd2, d); chk("R3 flag after flush", d[1], 0);
    rd(2'd3, d); chk("R3 empty after flush", d, 0);

    // R9 break
    @(negedge clk); rx_break = 1'b1;
    @(negedge clk); rx_break = 1'b0;
    rd(2'd2, d); chk("R9 break set", d[4], 1);
    wr(2'd2, 8'hEF);
    rd(2'd2, d); chk("R9 break cleared", d[4], 0);

    done = 1;
    finish_run();
  end
endmodule